// File: doc/BRIEF.md
# In-Order Commit Buffer with Precise Exception Flush

This block lets a pipeline finish instructions out of order in execution units of different latency while the architectural register file is written strictly in program order. At decode each instruction claims a slot in a circular buffer and records its program counter and destination register. The slot number comes back to the issuer as a tag. When an execution unit finishes, it reports the tag together with a result and an exception flag. Results wait in the buffer until their slot is the oldest. A short add that finishes early is held behind an older long-latency multiply.

Only the oldest slot may leave the buffer, and no more than one slot leaves per cycle. A finished oldest slot without an exception is offered to the register file. A finished oldest slot with an exception causes a flush instead. The flush reports that slot's program counter as the restart point and discards it together with every younger slot, finished or not. No later instruction's result reaches the register file.

There are three streams. Allocation is a valid/ready stream, and decode must hold its request while `alloc_ready` is low. Commit is a valid/ready stream, and the register file may apply back-pressure through `cmt_ready`; the offered slot and its fields stay unchanged until it is accepted. Completion has no ready: the block always takes a completion report, even when it ignores it. The exception report is a one-cycle pulse with no handshake.

Top module: `rob_core`

## Requirements
- R1: While reset is held and right after it, the buffer is empty: `alloc_ready`=1, `rob_full`=0, `cmt_valid`=0, `exc_valid`=0 and `alloc_tag`=0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both high. The accepted entry gets the tag shown on `alloc_tag`. Successive accepted allocations get consecutive tags, counting up modulo DEPTH.
- R3: With DEPTH entries in use, `rob_full`=1 and `alloc_ready`=0. An `alloc_valid` in that state changes nothing.
- R4: A completion to a live, unfinished tag stores its result and exception flag. Completions may arrive in any order relative to allocation order.
- R5: `cmt_valid` is high exactly when the oldest entry is finished and has no exception. `cmt_rd`, `cmt_data` and `cmt_pc` then show that entry's destination, result and PC.
- R6: While `cmt_valid`=1 and `cmt_ready`=0, the entry is kept and the commit outputs hold their values into the next cycle.
- R7: At most one entry commits per cycle. Commits appear in allocation order.
- R8: When the oldest entry is finished with an exception, `exc_valid` pulses for one cycle with `exc_pc` equal to its PC. `cmt_valid` stays 0. The next cycle the buffer is empty, the next tag equals the flushed oldest tag, and no younger result is ever committed.
- R9: A completion is ignored if its tag is not live, if its entry has already finished, or if it arrives in a flush cycle.
- R10: In a flush cycle `alloc_ready`=0, so no allocation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode requests an entry |
| alloc_ready | output | 1 | Entry can be taken this cycle |
| alloc_pc | input | PC_W | PC of the allocating instruction |
| alloc_rd | input | RD_W | Destination register index |
| alloc_tag | output | TW | Tag the next allocation receives |
| rob_full | output | 1 | All entries in use |
| cpl_valid | input | 1 | Execution unit reports completion |
| cpl_tag | input | TW | Tag of the finishing entry |
| cpl_data | input | DATA_W | Result value |
| cpl_exc | input | 1 | Instruction raised an exception |
| cmt_valid | output | 1 | Oldest entry offered to register file |
| cmt_ready | input | 1 | Register file accepts the commit |
| cmt_rd | output | RD_W | Destination of committing entry |
| cmt_data | output | DATA_W | Result of committing entry |
| cmt_pc | output | PC_W | PC of committing entry |
| exc_valid | output | 1 | Flush pulse for a precise exception |
| exc_pc | output | PC_W | Restart PC |

## Verification
The collision that matters is a flush in the same cycle as an allocation request and a completion report. The flush must win: the allocation is refused and the completion is dropped. The bench keeps `alloc_valid` high most of the time and sends completions freely, so exceptions reaching the head usually coincide with both kinds of request. A behavioural queue model decides each cycle which of the three takes effect, and any difference in tags, commit stream or restart PC afterwards exposes a wrong priority. Random `cmt_ready` back-pressure also makes commit and allocation fall into the same cycle while the buffer is full.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_EMPTY  = 2'd0,
    HEAD_WAIT   = 2'd1,
    HEAD_COMMIT = 2'd2,
    HEAD_FLUSH  = 2'd3
  } head_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] count;

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      tail  <= head;
      count <= '0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && (tail == $past(head))); // R8
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int RD_W   = 5,
  parameter int DATA_W = 32,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [TW-1:0]     alloc_idx,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [RD_W-1:0]   alloc_rd,
  input  logic              cpl_valid,
  input  logic [TW-1:0]     cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_exc,
  input  logic              retire,
  input  logic              flush,
  input  logic [TW-1:0]     head_idx,
  output logic              head_valid,
  output logic              head_done,
  output logic              head_exc,
  output logic [RD_W-1:0]   head_rd,
  output logic [DATA_W-1:0] head_data,
  output logic [PC_W-1:0]   head_pc
);
  logic [DEPTH-1:0] vld, dn, ex;
  logic [PC_W-1:0]   pc_arr   [DEPTH];
  logic [RD_W-1:0]   rd_arr   [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];
  logic cpl_hit;

  // a completion lands only on a live, unfinished slot and never during a flush
  assign cpl_hit = cpl_valid && !flush && (int'(cpl_tag) < DEPTH) &&
                   vld[cpl_tag] && !dn[cpl_tag];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              v_q, d_q, e_q;
    logic [PC_W-1:0]   pc_q;
    logic [RD_W-1:0]   rd_q;
    logic [DATA_W-1:0] data_q;
    logic here_alloc, here_retire, here_cpl;

    assign here_alloc  = alloc_we && (alloc_idx == TW'(i));
    assign here_retire = retire && (head_idx == TW'(i));
    assign here_cpl    = cpl_hit && (cpl_tag == TW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0; d_q <= 1'b0; e_q <= 1'b0;
      end else if (flush) begin
        v_q <= 1'b0; d_q <= 1'b0; e_q <= 1'b0;
      end else if (here_alloc) begin
        v_q <= 1'b1; d_q <= 1'b0; e_q <= 1'b0;
      end else if (here_retire) begin
        v_q <= 1'b0; d_q <= 1'b0;
      end else if (here_cpl) begin
        d_q <= 1'b1; e_q <= cpl_exc;
      end
    end

    always_ff @(posedge clk) begin
      if (here_alloc) begin
        pc_q <= alloc_pc;
        rd_q <= alloc_rd;
      end
      if (here_cpl) data_q <= cpl_data;
    end

    assign vld[i]      = v_q;
    assign dn[i]       = d_q;
    assign ex[i]       = e_q;
    assign pc_arr[i]   = pc_q;
    assign rd_arr[i]   = rd_q;
    assign data_arr[i] = data_q;
  end

  assign head_valid = vld[head_idx];
  assign head_done  = dn[head_idx];
  assign head_exc   = ex[head_idx];
  assign head_rd    = rd_arr[head_idx];
  assign head_data  = data_arr[head_idx];
  assign head_pc    = pc_arr[head_idx];

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> !vld[alloc_idx]); // R2
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && head_done && !retire && !flush) |=> head_done && $stable(head_data)); // R9
endmodule

// File: rtl/rob_head_ctl.sv
module rob_head_ctl
  import rob_pkg::*;
(
  input  logic      head_valid,
  input  logic      head_done,
  input  logic      head_exc,
  input  logic      cmt_ready,
  output head_act_e act,
  output logic      cmt_valid,
  output logic      exc_valid,
  output logic      retire,
  output logic      flush
);
  always_comb begin
    if (!head_valid)     act = HEAD_EMPTY;
    else if (!head_done) act = HEAD_WAIT;
    else if (head_exc)   act = HEAD_FLUSH;
    else                 act = HEAD_COMMIT;
  end

  assign cmt_valid = (act == HEAD_COMMIT);
  assign exc_valid = (act == HEAD_FLUSH);
  assign retire    = cmt_valid && cmt_ready;
  assign flush     = exc_valid;
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int RD_W   = 5,
  parameter int DATA_W = 32,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [RD_W-1:0]   alloc_rd,
  output logic [TW-1:0]     alloc_tag,
  output logic              rob_full,
  input  logic              cpl_valid,
  input  logic [TW-1:0]     cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_exc,
  output logic              cmt_valid,
  input  logic              cmt_ready,
  output logic [RD_W-1:0]   cmt_rd,
  output logic [DATA_W-1:0] cmt_data,
  output logic [PC_W-1:0]   cmt_pc,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc
);
  logic [TW-1:0] head, tail;
  logic full, empty, push, retire, flush;
  logic h_valid, h_done, h_exc;
  logic [RD_W-1:0]   h_rd;
  logic [DATA_W-1:0] h_data;
  logic [PC_W-1:0]   h_pc;
  head_act_e act;

  assign alloc_ready = !full && !flush;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign rob_full    = full;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(retire), .flush(flush),
    .head(head), .tail(tail), .full(full), .empty(empty)
  );

  rob_entries #(.DEPTH(DEPTH), .PC_W(PC_W), .RD_W(RD_W), .DATA_W(DATA_W)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(push), .alloc_idx(tail), .alloc_pc(alloc_pc), .alloc_rd(alloc_rd),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_exc(cpl_exc),
    .retire(retire), .flush(flush), .head_idx(head),
    .head_valid(h_valid), .head_done(h_done), .head_exc(h_exc),
    .head_rd(h_rd), .head_data(h_data), .head_pc(h_pc)
  );

  rob_head_ctl u_ctl (
    .head_valid(h_valid), .head_done(h_done), .head_exc(h_exc), .cmt_ready(cmt_ready),
    .act(act), .cmt_valid(cmt_valid), .exc_valid(exc_valid),
    .retire(retire), .flush(flush)
  );

  assign cmt_rd   = h_rd;
  assign cmt_data = h_data;
  assign cmt_pc   = h_pc;
  assign exc_pc   = h_pc;

  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> cmt_valid && $stable(cmt_rd) && $stable(cmt_data) && $stable(cmt_pc)); // R6
  AST_FLUSH_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !alloc_ready); // R10
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid && !cmt_valid); // R8
  AST_EXCL_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmt_valid, exc_valid})); // R5
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> !alloc_ready); // R3
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !cmt_valid && !exc_valid); // R1
endmodule

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;
  localparam int DEPTH = 8, PC_W = 32, RD_W = 5, DATA_W = 32;
  localparam int TW = $clog2(DEPTH);
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, alloc_valid, alloc_ready, rob_full, cpl_valid, cpl_exc;
  logic cmt_valid, cmt_ready, exc_valid;
  logic [PC_W-1:0] alloc_pc, cmt_pc, exc_pc;
  logic [RD_W-1:0] alloc_rd, cmt_rd;
  logic [TW-1:0] alloc_tag, cpl_tag;
  logic [DATA_W-1:0] cpl_data, cmt_data;

  rob_core #(.DEPTH(DEPTH), .PC_W(PC_W), .RD_W(RD_W), .DATA_W(DATA_W)) dut (.*);

  typedef struct {
    int tag; logic [PC_W-1:0] pc; logic [RD_W-1:0] rd;
    bit done; bit exc; logic [DATA_W-1:0] data;
  } ent_t;
  ent_t q[$];
  int nxt = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [PC_W-1:0] pc_ctr = 32'h1000;

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; alloc_valid = 0; alloc_pc = '0; alloc_rd = '0;
    cpl_valid = 0; cpl_tag = '0; cpl_data = '0; cpl_exc = 0; cmt_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "rob_full", rob_full, 0);
    chk("R1", "cmt_valid", cmt_valid, 0);
    chk("R1", "exc_valid", exc_valid, 0);
    chk("R1", "alloc_tag", alloc_tag, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      bit e_full, e_exc, e_cv, e_ar;
      int a_pct, c_pct, r_pct, x_pct;
      int open[$];
      e_full = (q.size() == DEPTH);
      e_exc  = (q.size() > 0) && q[0].done && q[0].exc;
      e_cv   = (q.size() > 0) && q[0].done && !q[0].exc;
      e_ar   = !e_full && !e_exc;
      if (cyc > 0) @(negedge clk);
      // compare outputs against the model
      chk("R3/R10", "alloc_ready", alloc_ready, e_ar);
      chk("R3", "rob_full", rob_full, e_full);
      chk("R2", "alloc_tag", alloc_tag, nxt);
      chk("R5/R9", "cmt_valid", cmt_valid, e_cv);
      chk("R8", "exc_valid", exc_valid, e_exc);
      if (e_cv) begin
        chk("R6", "cmt_rd", cmt_rd, q[0].rd);
        chk("R4", "cmt_data", cmt_data, q[0].data);
        chk("R7", "cmt_pc", cmt_pc, q[0].pc);
      end
      if (e_exc) chk("R8", "exc_pc", exc_pc, q[0].pc);

      // phase-dependent stimulus mix
      if (cyc < 30)        begin a_pct = 100; c_pct = 0;  r_pct = 0;  x_pct = 0;  end
      else if (cyc < 60)   begin a_pct = 0;   c_pct = 90; r_pct = 30; x_pct = 0;  end
      else if (cyc < 2000) begin a_pct = 80;  c_pct = 60; r_pct = 60; x_pct = 8;  end
      else                 begin a_pct = 50;  c_pct = 80; r_pct = 85; x_pct = 20; end

      alloc_valid = ($urandom_range(99) < a_pct);
      alloc_pc    = pc_ctr;
      alloc_rd    = RD_W'($urandom);
      cmt_ready   = ($urandom_range(99) < r_pct);
      cpl_valid   = 0;
      cpl_exc     = ($urandom_range(99) < x_pct);
      cpl_data    = $urandom;
      foreach (q[k]) if (!q[k].done) open.push_back(k);
      if ($urandom_range(99) < c_pct) begin
        if (open.size() > 0 && $urandom_range(9) != 0) begin
          cpl_valid = 1;
          cpl_tag   = TW'(q[open[$urandom_range(open.size() - 1)]].tag);
        end else begin
          // R9: target a tag that is not live
          for (int t = 0; t < DEPTH; t++) begin
            bit live = 0;
            foreach (q[k]) if (q[k].tag == t) live = 1;
            if (!live && !cpl_valid) begin cpl_valid = 1; cpl_tag = TW'(t); end
          end
        end
      end

      // model next state
      if (e_exc) begin
        nxt = q[0].tag;
        q.delete();
      end else begin
        if (e_cv && cmt_ready) void'(q.pop_front());
        if (cpl_valid)
          foreach (q[k])
            if (q[k].tag == int'(cpl_tag) && !q[k].done) begin
              q[k].done = 1; q[k].exc = cpl_exc; q[k].data = cpl_data;
            end
        if (alloc_valid && e_ar) begin
          ent_t e;
          e.tag = nxt; e.pc = alloc_pc; e.rd = alloc_rd;
          e.done = 0; e.exc = 0; e.data = '0;
          q.push_back(e);
          nxt = (nxt + 1) % DEPTH;
          pc_ctr = pc_ctr + 4;
        end
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule